// File: doc/BRIEF.md
# PCI Configuration Header Responder

This block answers configuration reads and writes aimed at the 64-byte standard header of a single PCI function. A request names a byte offset, an access size of 1, 2 or 4 bytes and, for writes, a 32-bit data word. Every request gets exactly one response: a one-cycle valid pulse carrying read data and an error flag, a fixed number of cycles after it was presented. Register updates take effect at the clock edge that accepts the request. Reads observe the state from before that edge.

Six base address registers are held in dedicated slots. Each slot has a power-of-two window size set by a parameter. Each slot answers the all-ones sizing probe with its size mask and keeps its read-only type bits. When a write leaves a nonzero base, the slot turns the stored value into a decoded window address by adding an I/O or memory space offset. It then raises that slot's enable. A one-cycle pulse tells the address decoder that the decoded ranges have changed. The block also holds an expansion-ROM base register, with its own probe rule, a writable command register, and a few writable byte fields. Identity and other read-only fields come from parameters.

Top module: `cfg_space_responder`

## Requirements
- R1: Only sizes 1, 2 and 4 (req_size_i values 1, 2, 4) are accepted. Any other size gives rsp_err_o=1 and rdata 0, and modifies no register.
- R2: An offset of 0x40 or above gives rsp_err_o=1 and rdata 0, and modifies no register.
- R3: A read returns the bytes starting at the offset, with the lowest address in bits 7:0. Bytes past the access size read as 0, and bytes past offset 0x3F read as 0. Offsets 0x00–0x03 hold the vendor/device word, 0x06–0x07 the status word, and 0x08–0x0B the revision/class word.
- R4: Every request yields exactly one response. rsp_valid_o is high for a single cycle, LATENCY cycles after the cycle in which the request was presented. Write responses carry rdata 0.
- R5: BAR n sits at offset 0x10+4n. Bit 0 is 1 for an I/O BAR and 0 for a memory BAR. The low 2 bits (I/O) or the low 4 bits (memory) never change.
- R6: A 4-byte write of 0xFFFFFFFF to a BAR stores ~(size-1) in the non-type bits and keeps the type bits. It does not change bar_base_o or bar_en_o and raises no range_chg_o.
- R7: Any other 4-byte write to a BAR stores the written value with the type bits replaced by the existing ones.
- R8: When a non-probe BAR write leaves a nonzero base field, bar_base_o for that BAR becomes base + IO_OFS (I/O) or base + MEM_OFS (memory), and bar_en_o for that BAR goes high. range_chg_o is high for the one cycle after the accepting edge. A write with a zero base field changes neither.
- R9: A 4-byte write of 0xFFFFFFFE to the ROM base at 0x30 makes it read 0xFFFFFFFF. Any other 4-byte value is stored as written.
- R10: The command word at 0x04 is written by a 2-byte write, or by a 4-byte write that updates only bits 15:0. The status word at 0x06 is never changed by any write.
- R11: 1-byte writes update interrupt line (0x3C), cache line size (0x0C) and latency timer (0x0D).
- R12: 1-byte writes to interrupt pin (0x3D), minimum grant (0x3E), maximum latency (0x3F) and revision/class bytes (0x08–0x0B) are ignored and complete with rsp_err_o=0.
- R13: Any other write below 0x40 of a legal size, including misaligned or wrong-size BAR accesses, is ignored and completes with rsp_err_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_offset_i | input | 8 | Byte offset into configuration space |
| req_size_i | input | 3 | Access size in bytes |
| req_wdata_i | input | 32 | Write data, little-endian lanes |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_err_o | output | 1 | Response error flag |
| rsp_rdata_o | output | 32 | Read data |
| bar_base_o | output | 192 | Decoded window base, 32 bits per BAR, BAR 0 lowest |
| bar_en_o | output | 6 | Decoded window valid per BAR |
| range_chg_o | output | 1 | Pulse when any decoded window changes |

## Verification
The hardest case to reach is a BAR that has been probed, then programmed, then probed again. The type bits must survive all three steps, and the decoded window must move only on the programming write. The stimulus sizes the BARs, programs some of them with data whose low bits are set, writes a zero-base value to another, and reads each one back. The range-change pulse and the decode outputs are sampled on the cycle right after each accepting edge. A scoreboard tags every request with the cycle its response is due, so a stretched, early or duplicated response strobe shows up as a mismatch.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;
    localparam int HDR_BYTES = 64;
    localparam int NUM_BARS  = 6;

    localparam logic [7:0] OFS_CMD      = 8'h04;
    localparam logic [7:0] OFS_REV      = 8'h08;
    localparam logic [7:0] OFS_CLS_LINE = 8'h0C;
    localparam logic [7:0] OFS_LAT_TMR  = 8'h0D;
    localparam logic [7:0] OFS_BAR0     = 8'h10;
    localparam logic [7:0] OFS_ROM      = 8'h30;
    localparam logic [7:0] OFS_INT_LINE = 8'h3C;
    localparam logic [7:0] OFS_INT_PIN  = 8'h3D;
    localparam logic [7:0] OFS_MIN_GNT  = 8'h3E;
    localparam logic [7:0] OFS_MAX_LAT  = 8'h3F;

    typedef struct packed {
        logic        valid;
        logic        err;
        logic [31:0] rdata;
    } rsp_t;

    typedef struct packed {
        logic [HDR_BYTES-1:0][7:0] hdr;
        logic [31:0]               rom;
    } regs_t;
endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot #(
    parameter int unsigned SIZE_LOG2 = 12,
    parameter bit          IS_IO     = 1'b0,
    parameter logic [31:0] IO_OFS    = 32'h0001_0000,
    parameter logic [31:0] MEM_OFS   = 32'h4000_0000
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] val_o,
    output logic [31:0] base_o,
    output logic        en_o,
    output logic        chg_o
);
    localparam int unsigned TB        = IS_IO ? 2 : 4;
    localparam logic [31:0] TMASK     = (32'd1 << TB) - 32'd1;
    localparam logic [31:0] SZMASK    = ~((32'd1 << SIZE_LOG2) - 32'd1);
    localparam logic [31:0] TYPE_INIT = IS_IO ? 32'd1 : 32'd0;
    localparam logic [31:0] SPACE_OFS = IS_IO ? IO_OFS : MEM_OFS;

    typedef struct packed {
        logic [31:0] val;
        logic [31:0] base;
        logic        en;
        logic        chg;
    } slot_t;

    slot_t d, q;

    always_comb begin
        d     = q;
        d.chg = 1'b0;
        if (wr_i) begin
            if (wdata_i == 32'hFFFF_FFFF) begin
                d.val = (SZMASK & ~TMASK) | (q.val & TMASK);
            end else begin
                d.val = (wdata_i & ~TMASK) | (q.val & TMASK);
                if ((wdata_i & ~TMASK) != 32'd0) begin
                    d.base = (wdata_i & ~TMASK) + SPACE_OFS;
                    d.en   = 1'b1;
                    d.chg  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '{val: TYPE_INIT, base: 32'd0, en: 1'b0, chg: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign val_o  = q.val;
    assign base_o = q.base;
    assign en_o   = q.en;
    assign chg_o  = q.chg;

    // R5
    type_bits_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.val & TMASK) == TYPE_INIT);

    // R6
    probe_keeps_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && wdata_i == 32'hFFFF_FFFF) |=> ($stable(q.base) && $stable(q.en) && !q.chg));

    // R8
    chg_implies_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.chg |-> q.en);
endmodule

// File: rtl/cfg_rsp_delay.sv
module cfg_rsp_delay
    import cfgsp_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  rsp_t rsp_i,
    output rsp_t rsp_o
);
    rsp_t [DEPTH-1:0] d, q;

    always_comb begin
        d[0] = rsp_i;
        for (int i = 1; i < DEPTH; i++) begin
            d[i] = q[i-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rsp_o = q[DEPTH-1];

    // R4
    idle_rsp_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !q[0].valid |-> (!q[0].err && q[0].rdata == 32'd0));
endmodule

// File: rtl/cfg_space_responder.sv
module cfg_space_responder
    import cfgsp_pkg::*;
#(
    parameter int          LATENCY       = 2,
    parameter logic [29:0] BAR_LOG2      = {5'd4, 5'd4, 5'd4, 5'd20, 5'd12, 5'd8},
    parameter logic [5:0]  BAR_IO        = 6'b000001,
    parameter logic [31:0] IO_OFS        = 32'h0001_0000,
    parameter logic [31:0] MEM_OFS       = 32'h4000_0000,
    parameter logic [31:0] VENDOR_DEVICE = 32'h5A17_1D0C,
    parameter logic [31:0] CLASS_REV     = 32'h0200_0003,
    parameter logic [15:0] STATUS_INIT   = 16'h0290,
    parameter logic [7:0]  INT_PIN       = 8'h01
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     req_valid_i,
    input  logic                     req_write_i,
    input  logic [7:0]               req_offset_i,
    input  logic [2:0]               req_size_i,
    input  logic [31:0]              req_wdata_i,
    output logic                     rsp_valid_o,
    output logic                     rsp_err_o,
    output logic [31:0]              rsp_rdata_o,
    output logic [NUM_BARS*32-1:0]   bar_base_o,
    output logic [NUM_BARS-1:0]      bar_en_o,
    output logic                     range_chg_o
);
    localparam logic [7:0] BAR_END = OFS_BAR0 + 8'(4 * NUM_BARS);

    function automatic regs_t init_regs();
        regs_t r = '0;
        for (int j = 0; j < 4; j++) begin
            r.hdr[j]     = VENDOR_DEVICE[8*j +: 8];
            r.hdr[8 + j] = CLASS_REV[8*j +: 8];
        end
        r.hdr[6]           = STATUS_INIT[7:0];
        r.hdr[7]           = STATUS_INIT[15:8];
        r.hdr[OFS_INT_PIN] = INT_PIN;
        return r;
    endfunction

    regs_t d, q;
    logic [NUM_BARS-1:0][31:0]   bar_val;
    logic [NUM_BARS-1:0]         bar_wr, bar_chg;
    logic [HDR_BYTES-1:0][7:0]   img;
    logic                        size_ok, off_ok, err;
    logic [2:0]                  nbytes;
    logic [8:0]                  idx;
    logic [7:0]                  rel;
    logic [31:0]                 rd;
    rsp_t                        rsp_in, rsp_out;

    // Read image: stored bytes overlaid with BAR and ROM contents
    always_comb begin
        img = q.hdr;
        for (int b = 0; b < NUM_BARS; b++) begin
            for (int j = 0; j < 4; j++) begin
                img[int'(OFS_BAR0) + 4*b + j] = bar_val[b][8*j +: 8];
            end
        end
        for (int j = 0; j < 4; j++) begin
            img[int'(OFS_ROM) + j] = q.rom[8*j +: 8];
        end
    end

    always_comb begin
        d       = q;
        bar_wr  = '0;
        err     = 1'b0;
        rd      = 32'd0;
        idx     = 9'd0;
        rel     = req_offset_i - OFS_BAR0;
        nbytes  = req_size_i;
        size_ok = (req_size_i == 3'd1) || (req_size_i == 3'd2) || (req_size_i == 3'd4);
        off_ok  = req_offset_i < 8'(HDR_BYTES);
        if (req_valid_i) begin
            if (!size_ok || !off_ok) begin
                err = 1'b1;
            end else if (req_write_i) begin
                case (req_size_i)
                    3'd1: begin
                        case (req_offset_i)
                            OFS_INT_LINE, OFS_CLS_LINE, OFS_LAT_TMR:
                                d.hdr[req_offset_i[5:0]] = req_wdata_i[7:0];
                            OFS_INT_PIN, OFS_MIN_GNT, OFS_MAX_LAT,
                            OFS_REV, OFS_REV + 8'd1, OFS_REV + 8'd2, OFS_REV + 8'd3: ;
                            default: err = 1'b1;
                        endcase
                    end
                    3'd2: begin
                        if (req_offset_i == OFS_CMD) begin
                            d.hdr[4] = req_wdata_i[7:0];
                            d.hdr[5] = req_wdata_i[15:8];
                        end else begin
                            err = 1'b1;
                        end
                    end
                    default: begin
                        if (req_offset_i >= OFS_BAR0 && req_offset_i < BAR_END &&
                            req_offset_i[1:0] == 2'b00) begin
                            bar_wr[rel[4:2]] = 1'b1;
                        end else if (req_offset_i == OFS_ROM) begin
                            d.rom = (req_wdata_i == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : req_wdata_i;
                        end else if (req_offset_i == OFS_CMD) begin
                            d.hdr[4] = req_wdata_i[7:0];
                            d.hdr[5] = req_wdata_i[15:8];
                        end else begin
                            err = 1'b1;
                        end
                    end
                endcase
            end else begin
                for (int j = 0; j < 4; j++) begin
                    idx = {1'b0, req_offset_i} + 9'(j);
                    if (3'(j) < nbytes && idx < 9'(HDR_BYTES)) begin
                        rd[8*j +: 8] = img[idx[5:0]];
                    end
                end
            end
        end
        rsp_in = '{valid: req_valid_i, err: err, rdata: rd};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= init_regs();
        end else begin
            q <= d;
        end
    end

    for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
        cfg_bar_slot #(
            .SIZE_LOG2 (int'(BAR_LOG2[5*b +: 5])),
            .IS_IO     (BAR_IO[b]),
            .IO_OFS    (IO_OFS),
            .MEM_OFS   (MEM_OFS)
        ) i_slot (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_i    (bar_wr[b]),
            .wdata_i (req_wdata_i),
            .val_o   (bar_val[b]),
            .base_o  (bar_base_o[32*b +: 32]),
            .en_o    (bar_en_o[b]),
            .chg_o   (bar_chg[b])
        );
    end

    cfg_rsp_delay #(.DEPTH(LATENCY)) i_delay (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rsp_i  (rsp_in),
        .rsp_o  (rsp_out)
    );

    assign rsp_valid_o = rsp_out.valid;
    assign rsp_err_o   = rsp_out.err;
    assign rsp_rdata_o = rsp_out.rdata;
    assign range_chg_o = |bar_chg;

    // R1
    bad_size_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_write_i && !size_ok) |=> ($stable(q) && !range_chg_o));

    // R2
    high_offset_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_write_i && !off_ok) |=> ($stable(q) && !range_chg_o));

    // R9
    rom_no_fe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.rom != 32'hFFFF_FFFE);

    // R10
    status_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(q.hdr[6]) && $stable(q.hdr[7]));

    // R12
    int_pin_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_write_i && req_size_i == 3'd1 && req_offset_i == OFS_INT_PIN)
        |=> $stable(q.hdr[OFS_INT_PIN]));
endmodule

// File: tb/test_cfg_space_responder.sv
module test_cfg_space_responder;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [7:0]   req_offset = 8'd0;
    logic [2:0]   req_size = 3'd0;
    logic [31:0]  req_wdata = 32'd0;
    logic         rsp_valid, rsp_err, range_chg;
    logic [31:0]  rsp_rdata;
    logic [191:0] bar_base;
    logic [5:0]   bar_en;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0] q_rd[$];
    bit          q_err[$];
    int          q_due[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cfg_space_responder #(.LATENCY(LAT)) i_cfg_space_responder (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .req_valid_i  (req_valid),
        .req_write_i  (req_write),
        .req_offset_i (req_offset),
        .req_size_i   (req_size),
        .req_wdata_i  (req_wdata),
        .rsp_valid_o  (rsp_valid),
        .rsp_err_o    (rsp_err),
        .rsp_rdata_o  (rsp_rdata),
        .bar_base_o   (bar_base),
        .bar_en_o     (bar_en),
        .range_chg_o  (range_chg)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input bit wr, input logic [7:0] off, input logic [2:0] sz,
                        input logic [31:0] wd, input logic [31:0] exp_rd,
                        input bit exp_err, input string tag);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_offset = off;
        req_size   = sz;
        req_wdata  = wd;
        q_rd.push_back(exp_rd);
        q_err.push_back(exp_err);
        q_due.push_back(cyc + LAT);
        q_tag.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    // Response monitor (R4: timing, single strobe per request)
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_rd.size() == 0) begin
                chk(1'b0, "R4 unexpected strobe", 32'd1, 32'd0);
            end else begin
                automatic logic [31:0] e_rd  = q_rd.pop_front();
                automatic bit          e_err = q_err.pop_front();
                automatic int          due   = q_due.pop_front();
                automatic string       tag   = q_tag.pop_front();
                chk(cyc == due, {"R4 timing ", tag}, 32'(cyc), 32'(due));
                chk(rsp_err == e_err, {tag, " err"}, 32'(rsp_err), 32'(e_err));
                chk(rsp_rdata == e_rd, {tag, " rdata"}, rsp_rdata, e_rd);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bar_en == 6'd0, "reset bar_en", 32'(bar_en), 32'd0);
        chk(!rsp_valid && !range_chg, "reset strobes", {30'd0, rsp_valid, range_chg}, 32'd0);

        // R3 reset contents and lanes
        send(0, 8'h00, 3'd4, 0, 32'h5A17_1D0C, 0, "R3 id word");
        send(0, 8'h02, 3'd2, 0, 32'h0000_5A17, 0, "R3 device half");
        send(0, 8'h06, 3'd2, 0, 32'h0000_0290, 0, "R3 status");
        send(0, 8'h01, 3'd1, 0, 32'h0000_001D, 0, "R3 byte lane");

        // R1 illegal size
        send(1, 8'h0C, 3'd3, 32'h77, 32'd0, 1, "R1 size3 write");
        send(0, 8'h0C, 3'd1, 0, 32'd0, 0, "R1 untouched");
        send(0, 8'h00, 3'd0, 0, 32'd0, 1, "R1 size0 read");

        // R2 high offsets
        send(1, 8'h40, 3'd1, 32'h55, 32'd0, 1, "R2 write 0x40");
        send(0, 8'h40, 3'd4, 0, 32'd0, 1, "R2 read 0x40");
        send(0, 8'hFC, 3'd4, 0, 32'd0, 1, "R2 read 0xFC");

        // R11 writable bytes
        send(1, 8'h3C, 3'd1, 32'h0B, 32'd0, 0, "R11 int line");
        send(1, 8'h0C, 3'd1, 32'h10, 32'd0, 0, "R11 cache line");
        send(1, 8'h0D, 3'd1, 32'h20, 32'd0, 0, "R11 latency");
        send(0, 8'h0C, 3'd2, 0, 32'h0000_2010, 0, "R11 readback");
        send(0, 8'h3C, 3'd4, 0, 32'h0000_010B, 0, "R3 R11 int word");
        send(0, 8'h3D, 3'd4, 0, 32'h0000_0001, 0, "R3 past end");

        // R12 silently ignored bytes
        send(1, 8'h3D, 3'd1, 32'hFF, 32'd0, 0, "R12 int pin");
        send(1, 8'h3F, 3'd1, 32'hFF, 32'd0, 0, "R12 max lat");
        send(1, 8'h08, 3'd1, 32'hEE, 32'd0, 0, "R12 revision");
        send(1, 8'h0A, 3'd1, 32'hEE, 32'd0, 0, "R12 class");
        send(0, 8'h08, 3'd4, 0, 32'h0200_0003, 0, "R12 class kept");
        send(0, 8'h3C, 3'd4, 0, 32'h0000_010B, 0, "R12 pin kept");

        // R13 other read-only writes
        send(1, 8'h00, 3'd1, 32'h99, 32'd0, 1, "R13 vendor byte");
        send(1, 8'h06, 3'd2, 32'h0, 32'd0, 1, "R13 status half");
        send(1, 8'h11, 3'd4, 32'h1234, 32'd0, 1, "R13 misaligned bar");
        send(1, 8'h10, 3'd2, 32'h1234, 32'd0, 1, "R13 half bar");
        send(0, 8'h00, 3'd4, 0, 32'h5A17_1D0C, 0, "R13 id kept");
        send(0, 8'h10, 3'd4, 0, 32'h0000_0001, 0, "R13 R5 bar0 kept");

        // R10 command
        send(1, 8'h04, 3'd2, 32'h0147, 32'd0, 0, "R10 cmd half");
        send(0, 8'h04, 3'd4, 0, 32'h0290_0147, 0, "R10 cmd read");
        send(1, 8'h04, 3'd4, 32'hFFFF_0006, 32'd0, 0, "R10 cmd word");
        send(0, 8'h04, 3'd4, 0, 32'h0290_0006, 0, "R10 status kept");

        // R6 R5 sizing probes
        send(1, 8'h10, 3'd4, 32'hFFFF_FFFF, 32'd0, 0, "R6 probe bar0");
        chk(!range_chg, "R6 no pulse", 32'(range_chg), 32'd0);
        send(1, 8'h14, 3'd4, 32'hFFFF_FFFF, 32'd0, 0, "R6 probe bar1");
        send(1, 8'h18, 3'd4, 32'hFFFF_FFFF, 32'd0, 0, "R6 probe bar2");
        chk(bar_en == 6'd0, "R6 no enable", 32'(bar_en), 32'd0);
        send(0, 8'h10, 3'd4, 0, 32'hFFFF_FF01, 0, "R6 R5 bar0 io size");
        send(0, 8'h14, 3'd4, 0, 32'hFFFF_F000, 0, "R6 bar1 size");
        send(0, 8'h18, 3'd4, 0, 32'hFFF0_0000, 0, "R6 bar2 size");

        // R7 R8 programming
        send(1, 8'h14, 3'd4, 32'h1234_5678, 32'd0, 0, "R7 bar1 write");
        chk(range_chg, "R8 pulse high", 32'(range_chg), 32'd1);
        chk(bar_en == 6'b000010, "R8 bar1 en", 32'(bar_en), 32'h2);
        chk(bar_base[63:32] == 32'h5234_5670, "R8 bar1 base", bar_base[63:32], 32'h5234_5670);
        @(negedge clk);
        chk(!range_chg, "R8 pulse one cycle", 32'(range_chg), 32'd0);
        send(0, 8'h14, 3'd4, 0, 32'h1234_5670, 0, "R7 bar1 read");
        send(1, 8'h10, 3'd4, 32'h0000_ABCE, 32'd0, 0, "R7 bar0 write");
        chk(bar_base[31:0] == 32'h0001_ABCC, "R8 bar0 io base", bar_base[31:0], 32'h0001_ABCC);
        chk(bar_en == 6'b000011, "R8 bar0 en", 32'(bar_en), 32'h3);
        send(0, 8'h10, 3'd4, 0, 32'h0000_ABCD, 0, "R5 R7 bar0 read");
        send(1, 8'h18, 3'd4, 32'h0000_000F, 32'd0, 0, "R8 zero base");
        chk(!range_chg, "R8 zero no pulse", 32'(range_chg), 32'd0);
        chk(bar_en == 6'b000011, "R8 zero no en", 32'(bar_en), 32'h3);
        send(0, 8'h18, 3'd4, 0, 32'h0000_0000, 0, "R7 bar2 read");
        send(1, 8'h14, 3'd4, 32'hFFFF_FFFF, 32'd0, 0, "R6 reprobe bar1");
        chk(bar_base[63:32] == 32'h5234_5670, "R6 window held", bar_base[63:32], 32'h5234_5670);
        send(0, 8'h14, 3'd4, 0, 32'hFFFF_F000, 0, "R6 R5 reprobe read");

        // R9 ROM base
        send(1, 8'h30, 3'd4, 32'hFFFF_FFFE, 32'd0, 0, "R9 rom probe");
        send(0, 8'h30, 3'd4, 0, 32'hFFFF_FFFF, 0, "R9 rom probe read");
        send(1, 8'h30, 3'd4, 32'h00C0_0001, 32'd0, 0, "R9 rom write");
        send(0, 8'h30, 3'd4, 0, 32'h00C0_0001, 0, "R9 rom read");

        repeat (LAT + 4) @(negedge clk);
        chk(q_rd.size() == 0, "R4 missing responses", 32'(q_rd.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule